// File: doc/BRIEF.md
# Autonomous Discriminator Threshold Finder

This block locates, without help from a host, the smallest injected pulse amplitude that makes one channel's discriminator respond. A single start command carries the channel number, the number of test pulses per trial, a lower and an upper code bound, and a settle time. The block then drives a pulse-height DAC code and waits for the DAC to settle. It fires a burst of test pulses and counts the discriminator edges that come back, then makes a decision. It repeats this cycle by successive approximation until one code is left, and returns that code with a status on a single-cycle done strobe.

The discriminator threshold itself is programmed before the command through a separate setting. This block only sweeps the injected amplitude. Each decision comes from a majority of the pulse responses in a burst, not from one sample, so occasional missed or spurious responses near the threshold do not steer the search off course.

Top module: `tsf_top`

## Requirements
- R1: While reset is asserted and right after it is released, `busy_o`, `done_o` and `pulse_o` are low, `dac_o` is 0 and `status_o` is 0.
- R2: A start is accepted only while `busy_o` is low. It latches the whole command, and `chan_o` shows the latched channel from then until the next accepted start. A start pulsed while busy changes neither the channel nor the search outcome.
- R3: After a new code is placed on `dac_o`, at least `settle_i`+1 clock cycles pass before the first test pulse of that trial.
- R4: The trials run in a fixed order: first the upper bound, then the lower bound, then 12 binary trials from bit 11 down to bit 0. A trial code at or below the lower bound is decided as "no response", and one at or above the upper bound as "response", with no pulses fired. Every other trial fires exactly N one-cycle pulses on `pulse_o`, where N is the burst size and a burst size of 0 counts as 1.
- R5: A trial counts as firing when twice the number of pulses that drew a response is at least N.
- R6: A discriminator rising edge is counted only within the listen window of the latest pulse (LISTEN_CYC cycles), and at most one edge is counted per pulse.
- R7: When the upper bound fires and the lower bound does not, `status_o` is 0 and `result_o` is the lowest code in (lower, upper] that fires.
- R8: When the upper bound does not fire, the search stops with `status_o` = 1 and `result_o` equal to the upper bound.
- R9: When the upper bound fires and the lower bound also fires, the search stops with `status_o` = 2 and `result_o` equal to the lower bound.
- R10: `done_o` is high for exactly one cycle, `busy_o` is low from that cycle on, and `result_o`/`status_o` hold their values until the next done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command strobe |
| chan_i | input | CH_W | Channel number of the command |
| burst_i | input | BURST_W | Test pulses per trial (0 means 1) |
| lo_i | input | CODE_W | Lower search bound code |
| hi_i | input | CODE_W | Upper search bound code |
| settle_i | input | SETTLE_W | DAC settle delay in cycles |
| disc_i | input | 1 | Discriminator output, asynchronous |
| busy_o | output | 1 | A search is in progress |
| chan_o | output | CH_W | Channel under test |
| dac_o | output | CODE_W | Pulse-height DAC code |
| pulse_o | output | 1 | Test pulse injector trigger |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | CODE_W | Code at threshold |
| status_o | output | 2 | 0 in range, 1 upper bound silent, 2 lower bound fires |

## Verification
The assertions assume that the discriminator answers a test pulse within a few cycles and goes quiet again before the next pulse. They also assume that a larger injected code never makes the channel less likely to respond. The bench model meets both: it answers each pulse with a short high level, or with a double blip, a fixed time after the pulse. Its response depends only on whether the DAC code is above the model threshold and on the pulse's position in the burst. Every miss or spurious pattern it injects is the same for every code on one side of the threshold, so the response curve stays monotone.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_SETTLE,
      ST_PULSE,
      ST_LISTEN,
      ST_DECIDE,
      ST_APPLY
   } tsf_state_e;

   typedef enum logic [1:0] {
      PH_UPPER,
      PH_LOWER,
      PH_SAR
   } tsf_phase_e;

   typedef enum logic [1:0] {
      TS_OK      = 2'd0,
      TS_NOFIRE  = 2'd1,
      TS_ALLFIRE = 2'd2
   } tsf_status_e;

endpackage

// File: rtl/tsf_timer.sv
module tsf_timer #(
   parameter int TW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);

   if (TW < 1) begin : g_bad_tw
      $error("tsf_timer: TW must be at least 1");
   end

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R3: an unloaded running count steps down by exactly one per cycle
   a_r3_tmr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/tsf_resp.sv
module tsf_resp #(
   parameter int SYNC_STAGES = 2,
   parameter int HW          = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          disc_i,
   input  logic          clear,
   input  logic          arm,
   input  logic          window,
   output logic [HW-1:0] hits
);

   logic disc_s;
   logic prev;
   logic hit;
   logic take;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign disc_s = disc_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= (sr << 1) | SYNC_STAGES'(disc_i);
      end
      assign disc_s = sr[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= disc_s;
   end

   assign take = window & disc_s & ~prev & ~hit & ~arm & ~clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit  <= 1'b0;
         hits <= '0;
      end else begin
         if (clear || arm) hit <= 1'b0;
         else if (take)    hit <= 1'b1;
         if (clear)        hits <= '0;
         else if (take)    hits <= hits + 1'b1;
      end
   end

   // R6: once a pulse has been credited, the count stays put until the next pulse
   a_r6_one_per_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !arm && !clear) |=> (hits == $past(hits)));

   // R6: outside a clear the count never shrinks
   a_r6_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (hits >= $past(hits)));

endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
   import tsf_pkg::*;
#(
   parameter int CODE_W     = 12,
   parameter int CH_W       = 4,
   parameter int BURST_W    = 8,
   parameter int SETTLE_W   = 10,
   parameter int LISTEN_CYC = 8,
   parameter int TW         = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [CH_W-1:0]     chan_i,
   input  logic [BURST_W-1:0]  burst_i,
   input  logic [CODE_W-1:0]   lo_i,
   input  logic [CODE_W-1:0]   hi_i,
   input  logic [SETTLE_W-1:0] settle_i,
   input  logic                tmr_expired,
   input  logic [BURST_W-1:0]  hits_i,
   output logic                tmr_load,
   output logic [TW-1:0]       tmr_val,
   output logic                resp_clear,
   output logic                resp_arm,
   output logic                window,
   output logic                busy_o,
   output logic [CH_W-1:0]     chan_o,
   output logic [CODE_W-1:0]   dac_o,
   output logic                pulse_o,
   output logic                done_o,
   output logic [CODE_W-1:0]   result_o,
   output logic [1:0]          status_o
);

   localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

   tsf_state_e          st;
   tsf_phase_e          phase;
   logic [IDX_W-1:0]    bit_idx;
   logic [CODE_W-1:0]   acc;
   logic [CODE_W-1:0]   lo_q, hi_q;
   logic [BURST_W-1:0]  burst_q;
   logic [SETTLE_W-1:0] settle_q;
   logic [BURST_W-1:0]  left;
   logic                fire_q;

   logic [CODE_W-1:0]   trial;
   logic [CODE_W-1:0]   sar_next;
   logic                skip, skip_fire, fire_meas;

   always_comb begin
      case (phase)
         PH_UPPER: trial = hi_q;
         PH_LOWER: trial = lo_q;
         default:  trial = acc | (CODE_W'(1) << bit_idx);
      endcase
   end

   assign skip      = (phase == PH_SAR) && ((trial <= lo_q) || (trial >= hi_q));
   assign skip_fire = (trial > lo_q);
   assign fire_meas = ({hits_i, 1'b0} >= {1'b0, burst_q});
   assign sar_next  = fire_q ? acc : trial;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         phase    <= PH_UPPER;
         bit_idx  <= '0;
         acc      <= '0;
         lo_q     <= '0;
         hi_q     <= '0;
         burst_q  <= '0;
         settle_q <= '0;
         left     <= '0;
         fire_q   <= 1'b0;
         chan_o   <= '0;
         dac_o    <= '0;
         done_o   <= 1'b0;
         result_o <= '0;
         status_o <= TS_OK;
      end else begin
         done_o <= 1'b0;
         case (st)
            ST_IDLE: if (start_i) begin
               chan_o   <= chan_i;
               lo_q     <= lo_i;
               hi_q     <= hi_i;
               settle_q <= settle_i;
               burst_q  <= (burst_i == '0) ? BURST_W'(1) : burst_i;
               phase    <= PH_UPPER;
               st       <= ST_SETUP;
            end
            ST_SETUP: if (skip) begin
               fire_q <= skip_fire;
               st     <= ST_APPLY;
            end else begin
               dac_o <= trial;
               left  <= burst_q;
               st    <= ST_SETTLE;
            end
            ST_SETTLE: if (tmr_expired) st <= ST_PULSE;
            ST_PULSE: begin
               left <= left - 1'b1;
               st   <= ST_LISTEN;
            end
            ST_LISTEN: if (tmr_expired) st <= (left == '0) ? ST_DECIDE : ST_PULSE;
            ST_DECIDE: begin
               fire_q <= fire_meas;
               st     <= ST_APPLY;
            end
            ST_APPLY: begin
               case (phase)
                  PH_UPPER: if (!fire_q) begin
                     result_o <= hi_q;
                     status_o <= TS_NOFIRE;
                     done_o   <= 1'b1;
                     st       <= ST_IDLE;
                  end else begin
                     phase <= PH_LOWER;
                     st    <= ST_SETUP;
                  end
                  PH_LOWER: if (fire_q) begin
                     result_o <= lo_q;
                     status_o <= TS_ALLFIRE;
                     done_o   <= 1'b1;
                     st       <= ST_IDLE;
                  end else begin
                     phase   <= PH_SAR;
                     acc     <= '0;
                     bit_idx <= IDX_W'(CODE_W - 1);
                     st      <= ST_SETUP;
                  end
                  default: begin
                     acc <= sar_next;
                     if (bit_idx == '0) begin
                        result_o <= sar_next + 1'b1;
                        status_o <= TS_OK;
                        done_o   <= 1'b1;
                        st       <= ST_IDLE;
                     end else begin
                        bit_idx <= bit_idx - 1'b1;
                        st      <= ST_SETUP;
                     end
                  end
               endcase
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign tmr_load   = ((st == ST_SETUP) && !skip) || (st == ST_PULSE);
   assign tmr_val    = (st == ST_PULSE) ? TW'(LISTEN_CYC) : TW'(settle_q);
   assign resp_clear = (st == ST_SETUP);
   assign resp_arm   = (st == ST_PULSE);
   assign window     = (st == ST_PULSE) || (st == ST_LISTEN);
   assign pulse_o    = (st == ST_PULSE);
   assign busy_o     = (st != ST_IDLE);

   // R3: the settle wait is left only once the timer has run out
   a_r3_settle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SETTLE && !tmr_expired) |=> (st == ST_SETTLE));

   // R4: the DAC code does not move in the cycle a pulse is fired
   a_r4_dac_steady: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> $stable(dac_o));

   // R5: the response tally can never exceed the pulses in the burst
   a_r5_hits_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DECIDE) |-> (hits_i <= burst_q));

   // R7: an in-range result lies inside the commanded bounds
   a_r7_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o == TS_OK) |-> (result_o > lo_q && result_o <= hi_q));

   // R10: completion strobe lasts one cycle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R2: the channel is frozen while a search runs
   a_r2_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(chan_o));

endmodule

// File: rtl/tsf_top.sv
module tsf_top #(
   parameter int CODE_W      = 12,
   parameter int CH_W        = 4,
   parameter int BURST_W     = 8,
   parameter int SETTLE_W    = 10,
   parameter int LISTEN_CYC  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [CH_W-1:0]     chan_i,
   input  logic [BURST_W-1:0]  burst_i,
   input  logic [CODE_W-1:0]   lo_i,
   input  logic [CODE_W-1:0]   hi_i,
   input  logic [SETTLE_W-1:0] settle_i,
   input  logic                disc_i,
   output logic                busy_o,
   output logic [CH_W-1:0]     chan_o,
   output logic [CODE_W-1:0]   dac_o,
   output logic                pulse_o,
   output logic                done_o,
   output logic [CODE_W-1:0]   result_o,
   output logic [1:0]          status_o
);

   localparam int LST_W = $clog2(LISTEN_CYC + 1);
   localparam int TW    = (SETTLE_W > LST_W) ? SETTLE_W : LST_W;

   if (CODE_W < 2) begin : g_bad_code
      $error("tsf_top: CODE_W must be at least 2");
   end
   if (BURST_W < 1) begin : g_bad_burst
      $error("tsf_top: BURST_W must be at least 1");
   end
   if (LISTEN_CYC < SYNC_STAGES + 4) begin : g_bad_listen
      $error("tsf_top: LISTEN_CYC too short for the response path");
   end

   logic               tmr_load, tmr_expired;
   logic [TW-1:0]      tmr_val;
   logic               resp_clear, resp_arm, window;
   logic [BURST_W-1:0] hits;

   tsf_timer #(.TW(TW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   tsf_resp #(.SYNC_STAGES(SYNC_STAGES), .HW(BURST_W)) i_resp (
      .clk    (clk),
      .rst_n  (rst_n),
      .disc_i (disc_i),
      .clear  (resp_clear),
      .arm    (resp_arm),
      .window (window),
      .hits   (hits)
   );

   tsf_ctrl #(
      .CODE_W     (CODE_W),
      .CH_W       (CH_W),
      .BURST_W    (BURST_W),
      .SETTLE_W   (SETTLE_W),
      .LISTEN_CYC (LISTEN_CYC),
      .TW         (TW)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .chan_i      (chan_i),
      .burst_i     (burst_i),
      .lo_i        (lo_i),
      .hi_i        (hi_i),
      .settle_i    (settle_i),
      .tmr_expired (tmr_expired),
      .hits_i      (hits),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .resp_clear  (resp_clear),
      .resp_arm    (resp_arm),
      .window      (window),
      .busy_o      (busy_o),
      .chan_o      (chan_o),
      .dac_o       (dac_o),
      .pulse_o     (pulse_o),
      .done_o      (done_o),
      .result_o    (result_o),
      .status_o    (status_o)
   );

endmodule

// File: tb/test_tsf_top.sv
module test_tsf_top;

   localparam int CLK_PERIOD = 10;
   localparam int CODE_W     = 12;
   localparam int CH_W       = 4;
   localparam int BURST_W    = 8;
   localparam int SETTLE_W   = 10;
   localparam int NVEC       = 12;
   localparam int WAIT_MAX   = 60000;

   typedef struct packed {
      logic [11:0] thr;
      logic [11:0] lo;
      logic [11:0] hi;
      logic [7:0]  n;
      logic [7:0]  miss;
      logic [7:0]  fls;
      logic        dbl;
      logic [9:0]  settle;
   } vec_t;

   // thr, lo, hi, burst, misses above thr, false hits below thr, double blip, settle
   localparam vec_t VEC [NVEC] = '{
      '{12'd1000, 12'd0,   12'd4095, 8'd1,   8'd0, 8'd0, 1'b0, 10'd3 },  // R7 plain
      '{12'd2048, 12'd100, 12'd3000, 8'd5,   8'd2, 8'd2, 1'b0, 10'd7 },  // R5 noisy both sides
      '{12'd1,    12'd0,   12'd10,   8'd4,   8'd2, 8'd0, 1'b0, 10'd0 },  // R5 exact tie fires
      '{12'd4095, 12'd0,   12'd4095, 8'd3,   8'd0, 8'd0, 1'b0, 10'd1 },  // R7 top code
      '{12'd3500, 12'd0,   12'd3000, 8'd2,   8'd0, 8'd0, 1'b0, 10'd2 },  // R8
      '{12'd200,  12'd500, 12'd4000, 8'd3,   8'd0, 8'd0, 1'b0, 10'd4 },  // R9
      '{12'd777,  12'd700, 12'd900,  8'd0,   8'd0, 8'd0, 1'b0, 10'd5 },  // R4 burst 0
      '{12'd1234, 12'd0,   12'd4095, 8'd3,   8'd0, 8'd1, 1'b1, 10'd2 },  // R6 double edge
      '{12'd3000, 12'd0,   12'd4095, 8'd3,   8'd2, 8'd0, 1'b0, 10'd0 },  // R5 R8 minority
      '{12'd50,   12'd10,  12'd4095, 8'd7,   8'd0, 8'd4, 1'b0, 10'd1 },  // R5 R9 majority false
      '{12'd301,  12'd300, 12'd302,  8'd2,   8'd0, 8'd0, 1'b0, 10'd50},  // R4 narrow window
      '{12'd2500, 12'd0,   12'd4095, 8'd255, 8'd0, 8'd0, 1'b0, 10'd0 }   // R4 long burst
   };

   logic                clk = 1'b0;
   logic                rst_n;
   logic                start_i;
   logic [CH_W-1:0]     chan_i;
   logic [BURST_W-1:0]  burst_i;
   logic [CODE_W-1:0]   lo_i, hi_i;
   logic [SETTLE_W-1:0] settle_i;
   logic                disc_i;
   logic                busy_o, pulse_o, done_o;
   logic [CH_W-1:0]     chan_o;
   logic [CODE_W-1:0]   dac_o, result_o;
   logic [1:0]          status_o;

   tsf_top #(
      .CODE_W(CODE_W), .CH_W(CH_W), .BURST_W(BURST_W), .SETTLE_W(SETTLE_W),
      .LISTEN_CYC(8), .SYNC_STAGES(2)
   ) i_tsf_top (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
      .burst_i(burst_i), .lo_i(lo_i), .hi_i(hi_i), .settle_i(settle_i),
      .disc_i(disc_i), .busy_o(busy_o), .chan_o(chan_o), .dac_o(dac_o),
      .pulse_o(pulse_o), .done_o(done_o), .result_o(result_o), .status_o(status_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   int   pcnt = 0;
   int   first_pc = -1;
   int   neff_cur = 1;
   vec_t cur = '0;
   logic [3:0] pat = 4'b0;

   always @(posedge clk) cyc = cyc + 1;

   // channel model: answers each pulse with a short level or a double blip
   always @(negedge clk) begin
      int  idx;
      bit  resp;
      if (pulse_o) begin
         if (first_pc < 0) first_pc = cyc;
         idx  = pcnt % neff_cur;
         pcnt = pcnt + 1;
         if (int'(dac_o) >= int'(cur.thr)) resp = (idx >= int'(cur.miss));
         else                              resp = (idx < int'(cur.fls));
         if (resp) pat = cur.dbl ? 4'b0101 : 4'b0011;
      end
      disc_i = pat[0];
      pat    = pat >> 1;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit fires_at(input vec_t v, input int c);
      int n;
      n = (v.n == 0) ? 1 : int'(v.n);
      if (c >= int'(v.thr)) return (2 * (n - int'(v.miss)) >= n);
      return (2 * int'(v.fls) >= n);
   endfunction

   task automatic expect_of(input vec_t v, output int res, output int st, output int steps);
      int acc, trial;
      bit f;
      steps = 1;
      if (!fires_at(v, int'(v.hi))) begin res = int'(v.hi); st = 1; return; end
      steps = 2;
      if (fires_at(v, int'(v.lo))) begin res = int'(v.lo); st = 2; return; end
      st  = 0;
      res = -1;
      for (int c = int'(v.lo) + 1; c <= int'(v.hi); c++) begin
         if (fires_at(v, c)) begin res = c; break; end
      end
      acc = 0;
      for (int b = CODE_W - 1; b >= 0; b--) begin
         trial = acc | (1 << b);
         if (trial <= int'(v.lo))      f = 1'b0;
         else if (trial >= int'(v.hi)) f = 1'b1;
         else begin steps++; f = fires_at(v, trial); end
         if (!f) acc = trial;
      end
   endtask

   initial begin
      int exp_res, exp_st, exp_steps, start_cyc, t, prev_res;
      rst_n = 1'b0; start_i = 1'b0; chan_i = '0; burst_i = '0;
      lo_i = '0; hi_i = '0; settle_i = '0;
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0 && done_o == 1'b0, "R1 busy/done in reset", {busy_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pulse_o == 1'b0, "R1 pulse after reset", pulse_o, 0);
      chk(dac_o == '0, "R1 dac after reset", dac_o, 0);
      chk(status_o == 2'd0 && busy_o == 1'b0, "R1 status/busy after reset", status_o, 0);
      prev_res = 0;

      for (int i = 0; i < NVEC; i++) begin
         cur      = VEC[i];
         neff_cur = (cur.n == 0) ? 1 : int'(cur.n);
         pcnt     = 0;
         first_pc = -1;
         expect_of(cur, exp_res, exp_st, exp_steps);
         chk(int'(result_o) == prev_res, "R10 result held before start", result_o, prev_res);

         start_i = 1'b1; chan_i = CH_W'(i); burst_i = cur.n;
         lo_i = cur.lo; hi_i = cur.hi; settle_i = cur.settle;
         @(negedge clk);
         start_i   = 1'b0;
         start_cyc = cyc;
         repeat (3) @(negedge clk);
         // R2: stray command while busy
         start_i = 1'b1; chan_i = CH_W'(i) ^ 4'h1; lo_i = '0; hi_i = '1; burst_i = 8'd1; settle_i = '0;
         @(negedge clk);
         start_i = 1'b0;

         t = 0;
         while (!done_o && t < WAIT_MAX) begin
            @(negedge clk);
            t++;
         end
         chk(t < WAIT_MAX, "R10 done reached (watchdog)", t, WAIT_MAX);

         if (exp_st == 1)      chk(int'(result_o) == exp_res, "R8 result", result_o, exp_res);
         else if (exp_st == 2) chk(int'(result_o) == exp_res, "R9 result", result_o, exp_res);
         else chk(int'(result_o) == exp_res,
                  (cur.dbl ? "R6 R7 result" : ((cur.miss != 0 || cur.fls != 0) ? "R5 R7 result" : "R7 result")),
                  result_o, exp_res);
         chk(int'(status_o) == exp_st, "R7 R8 R9 status", status_o, exp_st);
         chk(chan_o == CH_W'(i), "R2 channel latched", chan_o, i);
         chk(pcnt == exp_steps * neff_cur, "R4 pulse total", pcnt, exp_steps * neff_cur);
         chk(first_pc - start_cyc >= int'(cur.settle) + 1, "R3 settle before first pulse",
             first_pc - start_cyc, int'(cur.settle) + 1);
         chk(busy_o == 1'b0, "R10 busy low at done", busy_o, 0);

         @(negedge clk);
         chk(done_o == 1'b0, "R10 done one cycle", done_o, 0);
         chk(int'(result_o) == exp_res && int'(status_o) == exp_st, "R10 outcome held",
             result_o, exp_res);
         prev_res = exp_res;
         repeat (4) @(negedge clk);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule